// File: doc/BRIEF.md
# Switchable CPU and Peripheral Clock Generator

This block takes one master oscillator and produces three derived clocks. The first is a fixed video dot clock at half the master rate. The second is a fixed baud reference at one quarter of the master rate. The third is a CPU clock that runs at either one fifth or one tenth of the master rate. A speed-select input picks the CPU rate. A single-cycle strobe accompanies each rising edge of the CPU clock, so that logic clocked by the master can act in step with the CPU.

The speed select may change at any moment. The generator samples it only on the master edge that closes a complete CPU period. That edge also starts a full high phase at the new ratio, so no high or low phase is ever cut short by a change of speed. At the nominal 20.2752 MHz master, the fast CPU clock is about 4.055 MHz and the slow one is about 2.03 MHz. Every high phase spans at least three master cycles, which is about 148 ns.

All outputs are registered. A synchronous reset puts all of them in a known phase.

Top module: `cpu_clk_gen`

## Requirements
- R1: While `rst` is high at a master edge, that edge sets `vidClk`=0, `baudClk`=0, `cpuClk`=1 and `cpuRise`=0, and selects the slow ratio.
- R2: Counting master edges from reset release as k=1,2,…, `vidClk` equals bit 0 of k, so it toggles on every master edge.
- R3: `baudClk` equals bit 1 of that same count k. It therefore toggles exactly on the edges where `vidClk` falls, and its period is four master cycles.
- R4: When the fast ratio is applied (`speedSel`=1 when sampled), each CPU period is 5 master cycles: high for 3 cycles, then low for 2.
- R5: When the slow ratio is applied (`speedSel`=0 when sampled), each CPU period is 10 master cycles: high for 5 cycles, then low for 5.
- R6: `speedSel` is sampled only on the master edge where `cpuClk` rises to begin a new period; the first period after reset is slow. A change of `speedSel` at any other time has no effect on `cpuClk` until that edge.
- R7: Even when `speedSel` toggles freely, no high phase of `cpuClk` lasts fewer than 3 master cycles, and no low phase lasts fewer than 2.
- R8: `cpuRise` is high for exactly the one master cycle that follows each edge on which `cpuClk` goes from 0 to 1, and is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| speedSel | input | 1 | CPU rate select: 1 selects divide-by-5, 0 selects divide-by-10 |
| vidClk | output | 1 | Video dot clock, master divided by 2 |
| baudClk | output | 1 | Baud reference, master divided by 4 |
| cpuClk | output | 1 | CPU clock, master divided by 5 or 10 |
| cpuRise | output | 1 | One-cycle strobe marking each rising edge of cpuClk |

## Verification
The assertions assume that `speedSel` is synchronous to the master clock. They also assume that reset is held for at least three master edges, so that every look into the past reaches cycles in which `cpuClk` was held high by reset. The stimulus changes `speedSel` only on falling master edges, and it holds reset for five edges at start and for three in the middle of the run. Beyond that, `speedSel` is unconstrained: it is toggled on every cycle for a stretch and flipped at random afterwards, so that changes fall at every phase position of a CPU period.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

  // Strobes from the period control to the clock datapath
  typedef struct packed {
    logic startHigh;  // current period ends; next cycle begins a high phase
    logic startLow;   // high phase ends; next cycle begins the low phase
  } cpuStrobe_t;

endpackage

// File: rtl/clkgen_ctrl.sv
module clkgen_ctrl
  import clkgen_pkg::*;
#(
  parameter int FAST_DIV  = 5,
  parameter int FAST_HIGH = 3,
  parameter int SLOW_DIV  = 10,
  parameter int SLOW_HIGH = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       speedSel,
  output cpuStrobe_t strb
);

  localparam int MAX_DIV = (FAST_DIV > SLOW_DIV) ? FAST_DIV : SLOW_DIV;
  localparam int CW      = $clog2(MAX_DIV);

  logic [CW-1:0] phCnt;
  logic [CW-1:0] lastCnt;
  logic [CW-1:0] highEnd;
  logic          curFast;

  always_comb begin
    lastCnt        = curFast ? CW'(FAST_DIV - 1)  : CW'(SLOW_DIV - 1);
    highEnd        = curFast ? CW'(FAST_HIGH - 1) : CW'(SLOW_HIGH - 1);
    strb.startHigh = (phCnt == lastCnt);
    strb.startLow  = (phCnt == highEnd);
  end

  // The ratio is latched only where a full period closes
  always_ff @(posedge clk) begin
    if (rst) begin
      phCnt   <= '0;
      curFast <= 1'b0;
    end else if (strb.startHigh) begin
      phCnt   <= '0;
      curFast <= speedSel;
    end else begin
      phCnt   <= phCnt + 1'b1;
    end
  end

  AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (rst)
    phCnt <= lastCnt);  // R4

  AST_RATIO_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    (phCnt != '0) |-> $stable(curFast));  // R6

  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (rst)
    !(strb.startHigh && strb.startLow));  // R5

endmodule

// File: rtl/clkgen_dp.sv
module clkgen_dp
  import clkgen_pkg::*;
#(
  parameter int FIX_BITS = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  cpuStrobe_t strb,
  output logic       vidClk,
  output logic       baudClk,
  output logic       cpuClk,
  output logic       cpuRise
);

  logic [FIX_BITS-1:0] fixCnt;

  // Fixed chain: each counter bit is a registered divided clock
  always_ff @(posedge clk) begin
    if (rst) fixCnt <= '0;
    else     fixCnt <= fixCnt + 1'b1;
  end

  assign vidClk  = fixCnt[0];
  assign baudClk = fixCnt[FIX_BITS-1];

  // CPU clock register, steered by the period control
  always_ff @(posedge clk) begin
    if (rst) begin
      cpuClk  <= 1'b1;
      cpuRise <= 1'b0;
    end else begin
      cpuRise <= strb.startHigh;
      if (strb.startHigh)     cpuClk <= 1'b1;
      else if (strb.startLow) cpuClk <= 1'b0;
    end
  end

  AST_VID_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (vidClk != $past(vidClk)));  // R2

  AST_BAUD_ON_VID_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(vidClk) |-> (baudClk != $past(baudClk)));  // R3

  AST_BAUD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$fell(vidClk) |-> $stable(baudClk));  // R3

  AST_MIN_HIGH: assert property (@(posedge clk) disable iff (rst)
    $fell(cpuClk) |-> ($past(cpuClk, 2) && $past(cpuClk, 3)));  // R7

  AST_MIN_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(cpuClk) |-> !$past(cpuClk, 2));  // R7

  AST_RISE_MARKED: assert property (@(posedge clk) disable iff (rst)
    $rose(cpuClk) |-> cpuRise);  // R8

  AST_MARK_ONLY_RISE: assert property (@(posedge clk) disable iff (rst)
    cpuRise |-> (cpuClk && !$past(cpuClk)));  // R8

endmodule

// File: rtl/cpu_clk_gen.sv
module cpu_clk_gen
  import clkgen_pkg::*;
#(
  parameter int FAST_DIV  = 5,
  parameter int FAST_HIGH = 3,
  parameter int SLOW_DIV  = 10,
  parameter int SLOW_HIGH = 5,
  parameter int FIX_BITS  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic speedSel,
  output logic vidClk,
  output logic baudClk,
  output logic cpuClk,
  output logic cpuRise
);

  cpuStrobe_t strb;

  clkgen_ctrl #(
    .FAST_DIV (FAST_DIV),
    .FAST_HIGH(FAST_HIGH),
    .SLOW_DIV (SLOW_DIV),
    .SLOW_HIGH(SLOW_HIGH)
  ) ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .speedSel(speedSel),
    .strb    (strb)
  );

  clkgen_dp #(
    .FIX_BITS(FIX_BITS)
  ) dp_i (
    .clk    (clk),
    .rst    (rst),
    .strb   (strb),
    .vidClk (vidClk),
    .baudClk(baudClk),
    .cpuClk (cpuClk),
    .cpuRise(cpuRise)
  );

endmodule

// File: tb/cpu_clk_gen_tb.sv
module cpu_clk_gen_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic speedSel = 1'b0;
  logic vidClk, baudClk, cpuClk, cpuRise;

  int nTests = 0;
  int nFail  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  // Bench reference model
  int mPh = 0;
  bit mFast = 1'b0;
  int mFix = 0;
  bit mStb = 1'b0;
  bit mRst = 1'b1;
  bit inR6 = 1'b0;

  // Run-length tracking for R7
  bit lastCpu = 1'b1;
  int runLen = 0;

  always #4 clk = ~clk;

  cpu_clk_gen dut_i (
    .clk(clk), .rst(rst), .speedSel(speedSel),
    .vidClk(vidClk), .baudClk(baudClk), .cpuClk(cpuClk), .cpuRise(cpuRise)
  );

  function automatic int periodLen(bit f);
    return f ? 5 : 10;
  endfunction

  function automatic bit expCpu(int ph, bit f);
    return ph < (f ? 3 : 5);
  endfunction

  task automatic check(string req, int act, int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    mRst   <= rst;
    if (rst) begin
      mPh <= 0; mFast <= 1'b0; mFix <= 0; mStb <= 1'b0;
    end else begin
      mFix <= (mFix + 1) % 4;
      if (mPh == periodLen(mFast) - 1) begin
        mPh <= 0; mFast <= speedSel; mStb <= 1'b1;
      end else begin
        mPh <= mPh + 1; mStb <= 1'b0;
      end
    end
  end

  always @(negedge clk) begin
    if (mRst) begin
      lastCpu = 1'b1;
      runLen = 0;
    end else if (!done) begin
      check("R2", vidClk, mFix % 2);
      check("R3", baudClk, mFix / 2);
      check(inR6 ? "R6" : (mFast ? "R4" : "R5"), cpuClk, expCpu(mPh, mFast));
      check("R8", cpuRise, mStb);
      if (cpuClk != lastCpu) begin
        if (lastCpu) check("R7", (runLen >= 3) ? 1 : 0, 1);
        else         check("R7", (runLen >= 2) ? 1 : 0, 1);
        runLen = 1;
        lastCpu = cpuClk;
      end else begin
        runLen++;
      end
    end
  end

  task automatic waitCycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic checkReset();
    check("R1", vidClk, 0);
    check("R1", baudClk, 0);
    check("R1", cpuClk, 1);
    check("R1", cpuRise, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    waitCycles(5);
    checkReset();
    rst = 1'b0;
    waitCycles(40);            // slow ratio, R5
    speedSel = 1'b1;
    waitCycles(40);            // fast ratio, R4
    inR6 = 1'b1;
    for (int i = 0; i < 30; i++) begin
      speedSel = ~speedSel;    // change on every cycle, R6 and R7
      @(negedge clk);
    end
    speedSel = 1'b0;           // one-cycle pulse, mostly missed by sampling
    waitCycles(12);
    inR6 = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      if (($urandom % 8) == 0) speedSel = ~speedSel;
      @(negedge clk);
    end
    rst = 1'b1;
    speedSel = 1'b1;           // R1: reset must still select slow first
    waitCycles(3);
    checkReset();
    rst = 1'b0;
    waitCycles(20);
    for (int i = 0; i < 500; i++) begin
      if (($urandom % 5) == 0) speedSel = ~speedSel;
      @(negedge clk);
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #400000;
    nTests++;
    nFail++;
    done = 1'b1;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule